// File: doc/BRIEF.md
# Flash Block-Protection Status Controller

This block keeps the write-protection state of a serial flash device and rules on every write command before it reaches the memory array. The state has three parts: a two-bit protection level, a spare third protection bit, and a lock bit. Together with an active-low hardware write-protect pin, these decide whether a write-status request may change the state. The protection level also decides whether a program, sector-erase or chip-erase request may go ahead.

The instruction decoder feeds the block one-cycle request strobes. A write-status strobe carries the new byte. A program, sector-erase or chip-erase strobe carries a target address. One cycle after a program or erase strobe, the block returns either a one-cycle grant pulse or a one-cycle deny pulse. The status byte is available on an output at all times, so the read-status path can return it.

The protected region is always the top part of the address space. The block finds it by looking only at the two most significant address bits. The address width is a parameter.

Top module: `flash_prot_ctrl`

## Requirements
- R1: After reset the status byte reads 0x0C: protection level 11, spare bit 0, lock bit 0. Grant and deny are both low.
- R2: The status byte places the lock bit at bit 7, the spare protection bit at bit 4 and the protection level at bits 3:2. Bits 6, 5, 1 and 0 always read 0, so an accepted write of 0xFF reads back as 0x9C.
- R3: An accepted write-status request loads bit 7, bit 4 and bits 3:2 of the written byte into the register, and the new value appears on the status output in the next cycle. A request is accepted when the write-protect pin is high or the lock bit is 0. Without a request the register holds its value.
- R4: When the write-protect pin is low and the lock bit is 1, a write-status request changes nothing, including the lock bit itself.
- R5: When the write-protect pin is high, a write-status request is accepted even if the lock bit is 1, and it can clear the lock bit.
- R6: The protection level maps to a region at the top of the 2^AW address space. Level 00 protects nothing. Level 01 protects the top quarter, where both top address bits are 1 (0xC000 to 0xFFFF for AW=16). Level 10 protects the top half, where the MSB is 1. Level 11 protects every address.
- R7: A program or sector-erase request inside the protected region gives a deny pulse in the next cycle. Outside the region it gives a grant pulse in the next cycle. Grant and deny are never high together.
- R8: A chip-erase request is granted only when the protection level is 00; otherwise it is denied. The spare bit has no effect on this.
- R9: The spare protection bit reads back as written and does not change the protected region or the chip-erase decision.
- R10: If several requests arrive in one cycle, chip erase is judged first, then sector erase, then program. Every request is judged against the register value from before any write-status request in the same cycle.
- R11: A cycle with no program or erase request gives neither grant nor deny in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| wrsr_req | input | 1 | Write-status request strobe |
| wrsr_data | input | 8 | New status byte for the write-status request |
| prog_req | input | 1 | Program request strobe |
| serase_req | input | 1 | Sector-erase request strobe |
| cerase_req | input | 1 | Chip-erase request strobe |
| req_addr | input | AW | Target address of the program or sector-erase request |
| status_q | output | 8 | Current status byte |
| grant | output | 1 | One-cycle pulse: the previous cycle's request is allowed |
| deny | output | 1 | One-cycle pulse: the previous cycle's request is refused |

## Verification
The bench probes the addresses on each side of the quarter and half boundaries. A design that decodes the level or the address bits wrongly grants 0xC000 or refuses 0xBFFF. It also drives every combination of pin and lock bit. A design that ignores the pin would let a locked register change, and one that lets the lock win over a high pin would keep software from clearing the lock. Same-cycle mixes of write-status and erase requests expose a design that judges requests against the freshly written level or that lets a program request mask a chip erase. The spare bit is set alone, to catch a design that lets it widen the protected region or block chip erase.

// File: rtl/prot_pkg.sv
package prot_pkg;

  localparam int STAT_W   = 8;
  localparam int LOCK_POS = 7;
  localparam int SPARE_POS = 4;
  localparam int LVL_LO   = 2;
  localparam int LVL_W    = 2;

  typedef enum logic [LVL_W-1:0] {
    LVL_NONE = 2'b00,
    LVL_QTR  = 2'b01,
    LVL_HALF = 2'b10,
    LVL_ALL  = 2'b11
  } prot_lvl_e;

  typedef enum logic [1:0] {
    REQ_NONE   = 2'b00,
    REQ_PROG   = 2'b01,
    REQ_SERASE = 2'b10,
    REQ_CHIP   = 2'b11
  } req_kind_e;

  typedef struct packed {
    logic      lock;
    logic      spare;
    prot_lvl_e lvl;
  } prot_fields_t;

  localparam prot_fields_t PROT_RST = '{lock: 1'b0, spare: 1'b0, lvl: LVL_ALL};

  function automatic logic [STAT_W-1:0] pack_status(input prot_fields_t f);
    logic [STAT_W-1:0] s;
    s = '0;
    s[LOCK_POS]                = f.lock;
    s[SPARE_POS]               = f.spare;
    s[LVL_LO +: LVL_W]         = f.lvl;
    return s;
  endfunction

  function automatic prot_fields_t unpack_status(input logic [STAT_W-1:0] s);
    prot_fields_t f;
    f.lock  = s[LOCK_POS];
    f.spare = s[SPARE_POS];
    f.lvl   = prot_lvl_e'(s[LVL_LO +: LVL_W]);
    return f;
  endfunction

endpackage

// File: rtl/prot_rst_sync.sv
module prot_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/prot_status_reg.sv
module prot_status_reg
  import prot_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n,
  input  logic              wr_req,
  input  logic [STAT_W-1:0] wr_data,
  output prot_fields_t      fields_q
);

  logic         wr_allow;
  logic         fields_en;
  prot_fields_t fields_d;
  logic         unused_wr_bits;

  // Lock only bites while the pin is held low.
  always_comb begin
    wr_allow  = wp_n | ~fields_q.lock;
    fields_en = wr_req & wr_allow;
    fields_d  = unpack_status(wr_data);
  end

  assign unused_wr_bits = ^{wr_data[6:5], wr_data[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fields_q <= PROT_RST;
    end else if (fields_en) begin
      fields_q <= fields_d;
    end
  end

  // R3: accepted write lands next cycle
  p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && (wp_n || !fields_q.lock)) |=>
      (fields_q.lock == $past(wr_data[LOCK_POS]) &&
       fields_q.spare == $past(wr_data[SPARE_POS]) &&
       fields_q.lvl == $past(wr_data[LVL_LO +: LVL_W])));

  // R3: no request, no change
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_req |=> $stable(fields_q));

  // R4: locked register frozen
  p_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wp_n && fields_q.lock) |=> $stable(fields_q));

endmodule

// File: rtl/prot_range_check.sv
module prot_range_check
  import prot_pkg::*;
(
  input  prot_lvl_e   lvl,
  input  logic [1:0]  addr_top,
  output logic        hit
);

  always_comb begin
    unique case (lvl)
      LVL_NONE: hit = 1'b0;
      LVL_QTR:  hit = &addr_top;
      LVL_HALF: hit = addr_top[1];
      LVL_ALL:  hit = 1'b1;
      default:  hit = 1'b1;
    endcase
  end

endmodule

// File: rtl/prot_req_gate.sv
module prot_req_gate
  import prot_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  prot_lvl_e lvl,
  input  logic      range_hit,
  input  logic      prog_req,
  input  logic      serase_req,
  input  logic      cerase_req,
  output logic      grant_q,
  output logic      deny_q
);

  req_kind_e kind;
  logic      grant_d;
  logic      deny_d;

  always_comb begin
    if (cerase_req) begin
      kind = REQ_CHIP;
    end else if (serase_req) begin
      kind = REQ_SERASE;
    end else if (prog_req) begin
      kind = REQ_PROG;
    end else begin
      kind = REQ_NONE;
    end
  end

  always_comb begin
    grant_d = 1'b0;
    deny_d  = 1'b0;
    unique case (kind)
      REQ_CHIP: begin
        grant_d = (lvl == LVL_NONE);
        deny_d  = (lvl != LVL_NONE);
      end
      REQ_SERASE, REQ_PROG: begin
        grant_d = ~range_hit;
        deny_d  = range_hit;
      end
      default: begin
        grant_d = 1'b0;
        deny_d  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= 1'b0;
      deny_q  <= 1'b0;
    end else begin
      grant_q <= grant_d;
      deny_q  <= deny_d;
    end
  end

  // R7: never both
  p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant_q && deny_q));

  // R11: quiet after an idle cycle
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!prog_req && !serase_req && !cerase_req) |=> (!grant_q && !deny_q));

  // R8: chip erase refused while any level is set
  p_chip_deny_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cerase_req && lvl != LVL_NONE) |=> deny_q);

endmodule

// File: rtl/flash_prot_ctrl.sv
module flash_prot_ctrl
  import prot_pkg::*;
#(
  parameter int AW         = 16,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n,
  input  logic              wrsr_req,
  input  logic [STAT_W-1:0] wrsr_data,
  input  logic              prog_req,
  input  logic              serase_req,
  input  logic              cerase_req,
  input  logic [AW-1:0]     req_addr,
  output logic [STAT_W-1:0] status_q,
  output logic              grant,
  output logic              deny
);

  localparam int TOP_HI = AW - 1;
  localparam int TOP_LO = AW - 2;

  logic         rst_int_n;
  prot_fields_t fields;
  logic [1:0]   addr_top;
  logic         range_hit;
  logic         unused_addr;

  assign addr_top    = req_addr[TOP_HI:TOP_LO];
  assign unused_addr = ^req_addr[TOP_LO-1:0];

  prot_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_int_n)
  );

  prot_status_reg u_status (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wp_n     (wp_n),
    .wr_req   (wrsr_req),
    .wr_data  (wrsr_data),
    .fields_q (fields)
  );

  prot_range_check u_range (
    .lvl      (fields.lvl),
    .addr_top (addr_top),
    .hit      (range_hit)
  );

  prot_req_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .lvl        (fields.lvl),
    .range_hit  (range_hit),
    .prog_req   (prog_req),
    .serase_req (serase_req),
    .cerase_req (cerase_req),
    .grant_q    (grant),
    .deny_q     (deny)
  );

  assign status_q = pack_status(fields);

  // R6: full level refuses any lone program request
  p_full_deny_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (prog_req && !cerase_req && status_q[LVL_LO +: LVL_W] == 2'b11) |=> deny);

  // R6: level none grants any lone program request
  p_none_grant_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (prog_req && !cerase_req && status_q[LVL_LO +: LVL_W] == 2'b00) |=> grant);

endmodule

// File: tb/test_flash_prot_ctrl.sv
module test_flash_prot_ctrl;

  localparam int AW = 16;

  logic          clk;
  logic          rst_n;
  logic          wp_n;
  logic          wrsr_req;
  logic [7:0]    wrsr_data;
  logic          prog_req;
  logic          serase_req;
  logic          cerase_req;
  logic [AW-1:0] req_addr;
  logic [7:0]    status_q;
  logic          grant;
  logic          deny;

  flash_prot_ctrl #(.AW(AW)) i_flash_prot_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wp_n       (wp_n),
    .wrsr_req   (wrsr_req),
    .wrsr_data  (wrsr_data),
    .prog_req   (prog_req),
    .serase_req (serase_req),
    .cerase_req (cerase_req),
    .req_addr   (req_addr),
    .status_q   (status_q),
    .grant      (grant),
    .deny       (deny)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int     vectors = 0;
  int     fails   = 0;
  int     cycles  = 0;
  string  tag     = "R1";

  // reference model state
  int     msync   = 0;
  bit     m_lock  = 0;
  int     m_lvl   = 3;
  bit     m_spare = 0;
  bit     m_grant = 0;
  bit     m_deny  = 0;

  function automatic bit in_region(int lvl, int a);
    int size;
    size = 1 << AW;
    if (lvl == 0) return 0;
    if (lvl == 1) return a >= (size / 4) * 3;
    if (lvl == 2) return a >= size / 2;
    return 1;
  endfunction

  task automatic model_reset();
    m_lock = 0; m_lvl = 3; m_spare = 0; m_grant = 0; m_deny = 0;
  endtask

  always @(negedge rst_n) begin
    msync = 0;
    model_reset();
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      msync = 0;
      model_reset();
    end else if (msync < 2) begin
      model_reset();
      msync++;
    end else begin
      m_grant = 0;
      m_deny  = 0;
      if (cerase_req) begin
        m_grant = (m_lvl == 0);
        m_deny  = (m_lvl != 0);
      end else if (serase_req || prog_req) begin
        m_deny  = in_region(m_lvl, int'(req_addr));
        m_grant = !m_deny;
      end
      if (wrsr_req && (wp_n || !m_lock)) begin
        m_lock  = wrsr_data[7];
        m_spare = wrsr_data[4];
        m_lvl   = int'(wrsr_data[3:2]);
      end
    end
  end

  task automatic check();
    logic [7:0] exp_s;
    exp_s = {m_lock, 2'b00, m_spare, 2'(m_lvl), 2'b00};
    vectors++;
    if (status_q !== exp_s || grant !== m_grant || deny !== m_deny) begin
      fails++;
      $display("FAIL %s status=%h grant=%b deny=%b expected status=%h grant=%b deny=%b",
               tag, status_q, grant, deny, exp_s, m_grant, m_deny);
    end
  endtask

  task automatic step(input logic wp, input logic wr, input logic [7:0] d,
                      input logic p, input logic s, input logic c,
                      input logic [AW-1:0] a);
    @(negedge clk);
    check();
    wp_n = wp; wrsr_req = wr; wrsr_data = d;
    prog_req = p; serase_req = s; cerase_req = c; req_addr = a;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(wp_n, 0, 8'h00, 0, 0, 0, '0);
  endtask

  task automatic wr(input logic wp, input logic [7:0] d);
    step(wp, 1, d, 0, 0, 0, '0);
    step(wp, 0, 8'h00, 0, 0, 0, '0);
  endtask

  task automatic prg(input logic [AW-1:0] a);
    step(wp_n, 0, 8'h00, 1, 0, 0, a);
    step(wp_n, 0, 8'h00, 0, 0, 0, '0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1; wp_n = 1; wrsr_req = 0; wrsr_data = 0;
    prog_req = 0; serase_req = 0; cerase_req = 0; req_addr = '0;
    #2 rst_n = 0;
    tag = "R1";
    idle(3);
    rst_n = 1;
    idle(4);

    tag = "R6";                       // level 11 protects everything
    prg(16'h0000); prg(16'h7FFF); prg(16'hFFFF);

    tag = "R3";
    wr(1, 8'h00);
    tag = "R6";                       // level 00
    prg(16'hFFFF);
    tag = "R8";
    step(1, 0, 0, 0, 0, 1, '0); idle(1);

    tag = "R6";                       // level 01 boundary
    wr(1, 8'h04);
    prg(16'hBFFF); prg(16'hC000); prg(16'h8000); prg(16'hFFFF);
    tag = "R8";
    step(1, 0, 0, 0, 0, 1, '0); idle(1);

    tag = "R6";                       // level 10 boundary
    wr(1, 8'h08);
    prg(16'h7FFF); prg(16'h8000);
    tag = "R7";
    step(1, 0, 0, 0, 1, 0, 16'hFFFF); step(1, 0, 0, 0, 1, 0, 16'h0001);
    step(1, 0, 0, 1, 0, 0, 16'h8001); idle(1);

    tag = "R9";                       // spare bit alone
    wr(1, 8'h10);
    prg(16'hFFFF);
    step(1, 0, 0, 0, 0, 1, '0); idle(1);

    tag = "R2";
    wr(1, 8'hFF);
    wr(1, 8'h63);

    tag = "R5";
    wr(1, 8'h80);
    wr(1, 8'h8C);
    tag = "R4";
    wr(0, 8'h00);
    wr(0, 8'h1C);
    step(0, 1, 8'h00, 1, 0, 0, 16'hFFFF); idle(1);
    tag = "R5";
    wr(1, 8'h00);
    tag = "R3";
    wr(0, 8'h88);
    tag = "R4";
    wr(0, 8'h04);
    tag = "R5";
    wr(1, 8'h08);

    tag = "R10";
    step(1, 0, 0, 1, 0, 1, 16'h0000); idle(1);  // chip erase wins, denied
    wr(1, 8'h00);
    step(1, 0, 0, 1, 1, 1, 16'hFFFF); idle(1);  // chip erase granted
    step(1, 1, 8'h0C, 1, 0, 0, 16'hFFFF);       // old level 00 applies
    step(1, 0, 0, 1, 0, 0, 16'hFFFF); idle(1);  // new level 11 applies

    tag = "R11";
    idle(3);

    tag = "R7";
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom;
      step(r[0] | r[1], r[2] & r[3], 8'($urandom), r[4] & r[5], r[6] & r[7] & r[8],
           r[9] & r[10] & r[11], AW'($urandom));
    end
    idle(2);

    @(negedge clk);
    check();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule